// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Condition Flags

This block is the integer divide unit of a processor datapath. A one-cycle start pulse hands it a dividend, a divisor, a mode and the register indices of the quotient and remainder destinations. It divides over many clock cycles and then returns, in a single-cycle completion pulse, the result words, the write enables for the two destination registers, and the updated condition flags N, Z, V and C. A zero divisor is not divided: the unit returns a divide-by-zero exception request instead.

Four operation shapes are covered. Word mode divides 32 bits by 16 and packs the 16-bit remainder and the 16-bit quotient into one destination. Long mode divides 32 bits by 32 and has a compact variant that writes only one destination. Quad mode takes its 64-bit dividend from the register pair and produces a 32-bit quotient and remainder. Each shape has an unsigned and a signed form. Register-file access is modelled by the operand inputs and the two write ports. Overflow follows measured silicon, not the "undefined" flags of a datasheet.

Internally the operands are turned into magnitudes, an unsigned restoring shift-subtract core produces one quotient bit per cycle over the full 64-bit dividend, and the signs, the overflow decision and the write enables are settled afterwards.

Top module: `divq_unit`

## Requirements
- R1: A zero divisor (in word mode only divisor bits 15:0 are examined) gives a result with dz_o=1 one clock after the start is sampled, with neither write enable asserted and N, Z, V, C unchanged.
- R2: C is 0 after every completed division, overflow included.
- R3: In word mode (mode_i=0) only the quotient port is written, with q_data_o[31:16] holding the remainder and q_data_o[15:0] the quotient; N is quotient bit 15 and Z is set when the 16-bit quotient is zero; divisor bits 31:16 are ignored.
- R4: Word-mode overflow occurs when the unsigned quotient exceeds 0xFFFF, or when the signed quotient lies outside -32768..32767.
- R5: On overflow V is 1, Z is 0, N keeps its previous value and no destination is written.
- R6: In quad mode (mode_i=2) the dividend is {r_opnd_i, q_opnd_i}; overflow occurs when the quotient does not fit 32 bits unsigned or signed 32 bits signed; otherwise N is quotient bit 31 and Z is set for a zero quotient.
- R7: Outside the compact variant, when q_idx_i equals r_idx_i only the quotient is written.
- R8: In long mode with compact_i=1, equal indices write only the quotient and different indices write only the remainder; N and Z still follow the quotient.
- R9: Signed quotients truncate toward zero and the remainder takes the sign of the dividend.
- R10: After reset all outputs are 0; a start sampled while idle gives done_o for one cycle, 66 clock edges later for a nonzero divisor (2*DATA_W+2); a start while busy_o is 1 is ignored.
- R11: Long mode (mode_i=1, code 3 behaves the same) divides q_opnd_i by divisor_i, never sets V, writes both destinations when the indices differ, and the signed case -2^31 / -1 returns 0x80000000 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a division when idle |
| mode_i | input | 2 | 0 word, 1 long, 2 quad, 3 long |
| sgn_i | input | 1 | Signed operands when 1 |
| compact_i | input | 1 | Compact write variant of long mode |
| q_idx_i | input | IDX_W | Quotient destination register index |
| r_idx_i | input | IDX_W | Remainder destination register index |
| q_opnd_i | input | DATA_W | Content of the quotient register (dividend low half) |
| r_opnd_i | input | DATA_W | Content of the remainder register (dividend high half in quad mode) |
| divisor_i | input | DATA_W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| dz_o | output | 1 | Divide-by-zero exception request |
| q_we_o | output | 1 | Write enable for the quotient destination |
| q_data_o | output | DATA_W | Data for the quotient destination |
| r_we_o | output | 1 | Write enable for the remainder destination |
| r_data_o | output | DATA_W | Data for the remainder destination |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The assertions take for granted that operands matter only in the cycle where start is accepted, that a zero divisor never reaches the shift-subtract core, and that the flag registers change only on a completion pulse, so a hold of N on overflow is seen as stability across the completion edge. The stimulus changes operands only at falling edges, keeps start high for a single cycle, and always waits for the completion pulse before launching the next operation, apart from one deliberate start issued during a busy division to show it is dropped.

// File: rtl/divq_pkg.sv
package divq_pkg;
  typedef enum logic [1:0] {
    MODE_WORD = 2'd0,
    MODE_LONG = 2'd1,
    MODE_QUAD = 2'd2,
    MODE_RSVD = 2'd3
  } div_mode_e;
endpackage

// File: rtl/divq_prep.sv
// Operand conditioning: widens the dividend and divisor for the selected
// mode, records their signs and hands magnitudes to the unsigned core.
module divq_prep #(
  parameter int DATA_W = 32
) (
  input  divq_pkg::div_mode_e mode_i,
  input  logic                sgn_i,
  input  logic [DATA_W-1:0]   lo_i,
  input  logic [DATA_W-1:0]   hi_i,
  input  logic [DATA_W-1:0]   dvs_i,
  output logic [2*DATA_W-1:0] dd_mag_o,
  output logic [DATA_W-1:0]   dv_mag_o,
  output logic                q_neg_o,
  output logic                r_neg_o,
  output logic                dv_zero_o
);
  localparam int DD_W   = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  logic [DD_W-1:0]   dd_raw;
  logic [DATA_W-1:0] dv_raw;
  logic              dd_ng, dv_ng;

  always_comb begin
    if (mode_i == divq_pkg::MODE_WORD) begin
      dv_raw = sgn_i ? {{HALF_W{dvs_i[HALF_W-1]}}, dvs_i[HALF_W-1:0]}
                     : {{HALF_W{1'b0}}, dvs_i[HALF_W-1:0]};
    end else begin
      dv_raw = dvs_i;
    end
    if (mode_i == divq_pkg::MODE_QUAD) begin
      dd_raw = {hi_i, lo_i};
    end else begin
      dd_raw = sgn_i ? {{DATA_W{lo_i[DATA_W-1]}}, lo_i} : {{DATA_W{1'b0}}, lo_i};
    end
    dd_ng     = sgn_i & dd_raw[DD_W-1];
    dv_ng     = sgn_i & dv_raw[DATA_W-1];
    dd_mag_o  = dd_ng ? (~dd_raw + 1'b1) : dd_raw;
    dv_mag_o  = dv_ng ? (~dv_raw + 1'b1) : dv_raw;
    q_neg_o   = dd_ng ^ dv_ng;
    r_neg_o   = dd_ng;
    dv_zero_o = (dv_raw == '0);
  end
endmodule

// File: rtl/divq_core.sv
// Unsigned restoring divider: one quotient bit per clock over the whole
// double-width dividend.
module divq_core #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [2*DATA_W-1:0] dd_i,
  input  logic [DATA_W-1:0]   dv_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0]   rem_o
);
  localparam int DD_W  = 2 * DATA_W;
  localparam int CNT_W = $clog2(DD_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] dvs;
  logic [DATA_W:0]   shifted;
  logic [DATA_W+1:0] trial;
  logic              take;
  logic [DATA_W-1:0] rem_nx;

  always_comb begin
    shifted = {rem_o, quo_o[DD_W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs};
    take    = ~trial[DATA_W+1];
    rem_nx  = take ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
      dvs    <= '0;
      quo_o  <= '0;
      rem_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt    <= CNT_W'(DD_W);
        dvs    <= dv_i;
        quo_o  <= dd_i;
        rem_o  <= '0;
      end else if (busy_o) begin
        rem_o <= rem_nx;
        quo_o <= {quo_o[DD_W-2:0], take};
        cnt   <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R9: partial remainder stays below the divisor throughout the run
  p_rem_below_div_r9 : assert property (@(posedge clk) disable iff (rst)
    (busy_o && dvs != '0) |-> (rem_o < dvs));

  // R10: a running division always has iterations left
  p_iter_left_r10 : assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt != '0));
endmodule

// File: rtl/divq_post.sv
// Result shaping: restores signs, decides overflow, picks destinations.
module divq_post #(
  parameter int DATA_W = 32
) (
  input  divq_pkg::div_mode_e mode_i,
  input  logic                sgn_i,
  input  logic                cmp_i,
  input  logic                same_i,
  input  logic                q_neg_i,
  input  logic                r_neg_i,
  input  logic [2*DATA_W-1:0] quo_mag_i,
  input  logic [DATA_W-1:0]   rem_mag_i,
  output logic [DATA_W-1:0]   q_data_o,
  output logic [DATA_W-1:0]   r_data_o,
  output logic                q_we_o,
  output logic                r_we_o,
  output logic                ovf_o,
  output logic                n_o,
  output logic                z_o
);
  localparam int DD_W   = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  logic [DD_W-1:0]   q_full;
  logic [DATA_W-1:0] r_full;
  logic [DD_W-HALF_W:0] w_top;
  logic [DATA_W:0]      l_top;
  logic              is_word, is_quad;

  always_comb begin
    q_full  = q_neg_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    r_full  = r_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    w_top   = q_full[DD_W-1:HALF_W-1];
    l_top   = q_full[DD_W-1:DATA_W-1];
    is_word = (mode_i == divq_pkg::MODE_WORD);
    is_quad = (mode_i == divq_pkg::MODE_QUAD);

    if (is_word) begin
      ovf_o = sgn_i ? !((&w_top) | ~(|w_top)) : (|w_top[DD_W-HALF_W:1]);
    end else if (is_quad) begin
      ovf_o = sgn_i ? !((&l_top) | ~(|l_top)) : (|l_top[DATA_W:1]);
    end else begin
      ovf_o = 1'b0;
    end

    if (is_word) begin
      q_data_o = {r_full[HALF_W-1:0], q_full[HALF_W-1:0]};
      r_data_o = r_full;
      n_o      = q_full[HALF_W-1];
      z_o      = (q_full[HALF_W-1:0] == '0);
      q_we_o   = !ovf_o;
      r_we_o   = 1'b0;
    end else begin
      q_data_o = q_full[DATA_W-1:0];
      r_data_o = r_full;
      n_o      = q_full[DATA_W-1];
      z_o      = (q_full[DATA_W-1:0] == '0);
      if (cmp_i && !is_quad) begin
        q_we_o = !ovf_o && same_i;
        r_we_o = !ovf_o && !same_i;
      end else begin
        q_we_o = !ovf_o;
        r_we_o = !ovf_o && !same_i;
      end
    end
  end
endmodule

// File: rtl/divq_unit.sv
module divq_unit #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              sgn_i,
  input  logic              compact_i,
  input  logic [IDX_W-1:0]  q_idx_i,
  input  logic [IDX_W-1:0]  r_idx_i,
  input  logic [DATA_W-1:0] q_opnd_i,
  input  logic [DATA_W-1:0] r_opnd_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dz_o,
  output logic              q_we_o,
  output logic [DATA_W-1:0] q_data_o,
  output logic              r_we_o,
  output logic [DATA_W-1:0] r_data_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int DD_W = 2 * DATA_W;

  divq_pkg::div_mode_e mode_in, mode_r;
  logic              sgn_r, cmp_r, same_r, qn_r, rn_r, busy_r;
  logic [DD_W-1:0]   dd_mag, quo_mag;
  logic [DATA_W-1:0] dv_mag, rem_mag;
  logic              pq_neg, pr_neg, dv_zero;
  logic              accept, core_busy, core_done;
  logic [DATA_W-1:0] pq_data, pr_data;
  logic              pq_we, pr_we, p_ovf, p_n, p_z;

  assign mode_in = divq_pkg::div_mode_e'(mode_i);
  assign accept  = start_i && !busy_r;
  assign busy_o  = busy_r;

  divq_prep #(.DATA_W(DATA_W)) prep_i (
    .mode_i(mode_in), .sgn_i(sgn_i), .lo_i(q_opnd_i), .hi_i(r_opnd_i),
    .dvs_i(divisor_i), .dd_mag_o(dd_mag), .dv_mag_o(dv_mag),
    .q_neg_o(pq_neg), .r_neg_o(pr_neg), .dv_zero_o(dv_zero)
  );

  divq_core #(.DATA_W(DATA_W)) core_i (
    .clk(clk), .rst(rst), .start_i(accept && !dv_zero), .dd_i(dd_mag),
    .dv_i(dv_mag), .busy_o(core_busy), .done_o(core_done),
    .quo_o(quo_mag), .rem_o(rem_mag)
  );

  divq_post #(.DATA_W(DATA_W)) post_i (
    .mode_i(mode_r), .sgn_i(sgn_r), .cmp_i(cmp_r), .same_i(same_r),
    .q_neg_i(qn_r), .r_neg_i(rn_r), .quo_mag_i(quo_mag), .rem_mag_i(rem_mag),
    .q_data_o(pq_data), .r_data_o(pr_data), .q_we_o(pq_we), .r_we_o(pr_we),
    .ovf_o(p_ovf), .n_o(p_n), .z_o(p_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r   <= divq_pkg::MODE_WORD;
      sgn_r    <= 1'b0;
      cmp_r    <= 1'b0;
      same_r   <= 1'b0;
      qn_r     <= 1'b0;
      rn_r     <= 1'b0;
      busy_r   <= 1'b0;
      done_o   <= 1'b0;
      dz_o     <= 1'b0;
      q_we_o   <= 1'b0;
      r_we_o   <= 1'b0;
      q_data_o <= '0;
      r_data_o <= '0;
      n_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      c_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      dz_o   <= 1'b0;
      q_we_o <= 1'b0;
      r_we_o <= 1'b0;
      if (accept) begin
        mode_r <= mode_in;
        sgn_r  <= sgn_i;
        cmp_r  <= compact_i;
        same_r <= (q_idx_i == r_idx_i);
        qn_r   <= pq_neg;
        rn_r   <= pr_neg;
        if (dv_zero) begin
          done_o <= 1'b1;
          dz_o   <= 1'b1;
        end else begin
          busy_r <= 1'b1;
        end
      end
      if (core_done) begin
        busy_r   <= 1'b0;
        done_o   <= 1'b1;
        c_o      <= 1'b0;
        q_we_o   <= pq_we;
        r_we_o   <= pr_we;
        q_data_o <= pq_data;
        r_data_o <= pr_data;
        if (p_ovf) begin
          v_o <= 1'b1;
          z_o <= 1'b0;
        end else begin
          v_o <= 1'b0;
          n_o <= p_n;
          z_o <= p_z;
        end
      end
    end
  end

  p_dz_no_write_r1 : assert property (@(posedge clk) disable iff (rst)
    dz_o |-> (!q_we_o && !r_we_o));

  p_dz_flags_hold_r1 : assert property (@(posedge clk) disable iff (rst)
    dz_o |-> $stable({n_o, z_o, v_o, c_o}));

  p_carry_clear_r2 : assert property (@(posedge clk) disable iff (rst)
    (done_o && !dz_o) |-> !c_o);

  p_word_one_dest_r3 : assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_r == divq_pkg::MODE_WORD) |-> !r_we_o);

  p_ovf_effects_r5 : assert property (@(posedge clk) disable iff (rst)
    (done_o && !dz_o && v_o) |-> (!q_we_o && !r_we_o && !z_o && $stable(n_o)));

  p_same_quotient_r7 : assert property (@(posedge clk) disable iff (rst)
    (done_o && same_r) |-> !r_we_o);

  p_compact_single_r8 : assert property (@(posedge clk) disable iff (rst)
    (done_o && !dz_o && cmp_r && mode_r != divq_pkg::MODE_WORD &&
     mode_r != divq_pkg::MODE_QUAD) |-> (q_we_o != r_we_o));

  p_busy_from_start_r10 : assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  p_core_tracks_busy_r10 : assert property (@(posedge clk) disable iff (rst)
    core_busy |-> busy_o);
endmodule

// File: tb/divq_unit_tb.sv
`timescale 1ns/1ps
module divq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        sgn_i = 1'b0;
  logic        compact_i = 1'b0;
  logic [2:0]  q_idx_i = 3'd0;
  logic [2:0]  r_idx_i = 3'd0;
  logic [31:0] q_opnd_i = '0;
  logic [31:0] r_opnd_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o, dz_o, q_we_o, r_we_o, n_o, z_o, v_o, c_o;
  logic [31:0] q_data_o, r_data_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  divq_unit #(.DATA_W(32), .IDX_W(3)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .sgn_i(sgn_i),
    .compact_i(compact_i), .q_idx_i(q_idx_i), .r_idx_i(r_idx_i),
    .q_opnd_i(q_opnd_i), .r_opnd_i(r_opnd_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .dz_o(dz_o), .q_we_o(q_we_o),
    .q_data_o(q_data_o), .r_we_o(r_we_o), .r_data_o(r_data_o),
    .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sgn;
    logic        cmp;
    logic [2:0]  qi;
    logic [2:0]  ri;
    logic [31:0] qop;
    logic [31:0] rop;
    logic [31:0] dvs;
    logic        dz;
    logic        qwe;
    logic        rwe;
    logic [31:0] qd;
    logic [31:0] rd;
    logic        n;
    logic        z;
    logic        v;
    logic [3:0]  req;
  } vec_t;

  // Walked in order: the expected N on overflow and on divide-by-zero is
  // the N left by the vector before.
  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // R3 R9: word signed -100/7 -> q -14, r -2
    '{2'd0,1'b1,1'b0,3'd1,3'd2,32'hFFFFFF9C,32'h0,32'h7,1'b0,1'b1,1'b0,32'hFFFEFFF2,32'h0,1'b1,1'b0,1'b0,4'd9},
    // R4 R5: word unsigned 0x10000/1 overflows, N held at 1
    '{2'd0,1'b0,1'b0,3'd1,3'd2,32'h00010000,32'h0,32'h1,1'b0,1'b0,1'b0,32'h0,32'h0,1'b1,1'b0,1'b1,4'd5},
    // R3: word unsigned 100/7
    '{2'd0,1'b0,1'b0,3'd1,3'd2,32'h64,32'h0,32'h7,1'b0,1'b1,1'b0,32'h0002000E,32'h0,1'b0,1'b0,1'b0,4'd3},
    // R4: word unsigned quotient exactly 0xFFFF fits
    '{2'd0,1'b0,1'b0,3'd1,3'd2,32'h0001FFFE,32'h0,32'h2,1'b0,1'b1,1'b0,32'h0000FFFF,32'h0,1'b1,1'b0,1'b0,4'd4},
    // R4: word signed +32768 does not fit
    '{2'd0,1'b1,1'b0,3'd1,3'd2,32'h00008000,32'h0,32'h1,1'b0,1'b0,1'b0,32'h0,32'h0,1'b1,1'b0,1'b1,4'd4},
    // R4: word signed -32768 fits
    '{2'd0,1'b1,1'b0,3'd1,3'd2,32'hFFFF8000,32'h0,32'h1,1'b0,1'b1,1'b0,32'h00008000,32'h0,1'b1,1'b0,1'b0,4'd4},
    // R3: zero quotient sets Z
    '{2'd0,1'b0,1'b0,3'd1,3'd2,32'h5,32'h0,32'h7,1'b0,1'b1,1'b0,32'h00050000,32'h0,1'b0,1'b1,1'b0,4'd3},
    // R1: word divisor with zero low half
    '{2'd0,1'b0,1'b0,3'd1,3'd2,32'h1234,32'h0,32'h00010000,1'b1,1'b0,1'b0,32'h0,32'h0,1'b0,1'b1,1'b0,4'd1},
    // R11: long unsigned 1000/33
    '{2'd1,1'b0,1'b0,3'd1,3'd2,32'h3E8,32'h0,32'h21,1'b0,1'b1,1'b1,32'h1E,32'hA,1'b0,1'b0,1'b0,4'd11},
    // R9: 7 / -2 -> -3 rem 1
    '{2'd1,1'b1,1'b0,3'd1,3'd2,32'h7,32'h0,32'hFFFFFFFE,1'b0,1'b1,1'b1,32'hFFFFFFFD,32'h1,1'b1,1'b0,1'b0,4'd9},
    // R9: -7 / 2 -> -3 rem -1
    '{2'd1,1'b1,1'b0,3'd1,3'd2,32'hFFFFFFF9,32'h0,32'h2,1'b0,1'b1,1'b1,32'hFFFFFFFD,32'hFFFFFFFF,1'b1,1'b0,1'b0,4'd9},
    // R7: same register, quotient only
    '{2'd1,1'b0,1'b0,3'd3,3'd3,32'h3E8,32'h3E8,32'h21,1'b0,1'b1,1'b0,32'h1E,32'h0,1'b0,1'b0,1'b0,4'd7},
    // R8: compact, different registers -> remainder only
    '{2'd1,1'b0,1'b1,3'd1,3'd2,32'h3E8,32'h0,32'h21,1'b0,1'b0,1'b1,32'h0,32'hA,1'b0,1'b0,1'b0,4'd8},
    // R8: compact, same register -> quotient only
    '{2'd1,1'b0,1'b1,3'd3,3'd3,32'h3E8,32'h3E8,32'h21,1'b0,1'b1,1'b0,32'h1E,32'h0,1'b0,1'b0,1'b0,4'd8},
    // R1: long divisor zero
    '{2'd1,1'b0,1'b0,3'd1,3'd2,32'h5,32'h0,32'h0,1'b1,1'b0,1'b0,32'h0,32'h0,1'b0,1'b0,1'b0,4'd1},
    // R5: quad overflow with N held at 0
    '{2'd2,1'b0,1'b0,3'd1,3'd2,32'h0,32'h5,32'h5,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,1'b0,1'b1,4'd5},
    // R6: quad unsigned 2^32/2 = 0x80000000 fits
    '{2'd2,1'b0,1'b0,3'd1,3'd2,32'h0,32'h1,32'h2,1'b0,1'b1,1'b1,32'h80000000,32'h0,1'b1,1'b0,1'b0,4'd6},
    // R6: quad unsigned 2^33/2 overflows
    '{2'd2,1'b0,1'b0,3'd1,3'd2,32'h0,32'h2,32'h2,1'b0,1'b0,1'b0,32'h0,32'h0,1'b1,1'b0,1'b1,4'd6},
    // R6 R9: quad signed -7/2
    '{2'd2,1'b1,1'b0,3'd1,3'd2,32'hFFFFFFF9,32'hFFFFFFFF,32'h2,1'b0,1'b1,1'b1,32'hFFFFFFFD,32'hFFFFFFFF,1'b1,1'b0,1'b0,4'd6},
    // R6: quad signed +2^31 does not fit
    '{2'd2,1'b1,1'b0,3'd1,3'd2,32'h80000000,32'h0,32'h1,1'b0,1'b0,1'b0,32'h0,32'h0,1'b1,1'b0,1'b1,4'd6},
    // R7: quad with one register for both
    '{2'd2,1'b0,1'b0,3'd3,3'd3,32'h10,32'h10,32'h20,1'b0,1'b1,1'b0,32'h80000000,32'h0,1'b1,1'b0,1'b0,4'd7},
    // R11: long signed -2^31 / -1
    '{2'd1,1'b1,1'b0,3'd1,3'd2,32'h80000000,32'h0,32'hFFFFFFFF,1'b0,1'b1,1'b1,32'h80000000,32'h0,1'b1,1'b0,1'b0,4'd11},
    // R3: word divisor upper half ignored, 100 / -7
    '{2'd0,1'b1,1'b0,3'd1,3'd2,32'h64,32'h0,32'hABCDFFF9,1'b0,1'b1,1'b0,32'h0002FFF2,32'h0,1'b1,1'b0,1'b0,4'd3}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_i    = v.mode;
    sgn_i     = v.sgn;
    compact_i = v.cmp;
    q_idx_i   = v.qi;
    r_idx_i   = v.ri;
    q_opnd_i  = v.qop;
    r_opnd_i  = v.rop;
    divisor_i = v.dvs;
  endtask

  task automatic run_op(input vec_t v, output int cyc);
    @(negedge clk);
    drive(v);
    start_i = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end while (!done_o && cyc < 300);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cyc;
    vec_t va, vb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(10, "reset busy", {31'b0, busy_o}, 32'h0);
    check(10, "reset done", {31'b0, done_o}, 32'h0);
    check(10, "reset flags", {28'b0, n_o, z_o, v_o, c_o}, 32'h0);
    check(10, "reset data", q_data_o | r_data_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i], cyc);
      check(VECS[i].req, $sformatf("v%0d done", i), {31'b0, done_o}, 32'h1);
      check(1, $sformatf("v%0d dz", i), {31'b0, dz_o}, {31'b0, VECS[i].dz});
      check(VECS[i].req, $sformatf("v%0d q_we", i), {31'b0, q_we_o}, {31'b0, VECS[i].qwe});
      check(VECS[i].req, $sformatf("v%0d r_we", i), {31'b0, r_we_o}, {31'b0, VECS[i].rwe});
      if (VECS[i].qwe) check(VECS[i].req, $sformatf("v%0d q_data", i), q_data_o, VECS[i].qd);
      if (VECS[i].rwe) check(VECS[i].req, $sformatf("v%0d r_data", i), r_data_o, VECS[i].rd);
      check(VECS[i].req, $sformatf("v%0d NZV", i), {29'b0, n_o, z_o, v_o},
            {29'b0, VECS[i].n, VECS[i].z, VECS[i].v});
      check(2, $sformatf("v%0d C", i), {31'b0, c_o}, 32'h0);   // R2
    end

    // R10: latency of a nonzero-divisor division and pulse width
    run_op(VECS[2], cyc);
    check(10, "latency", cyc, 32'd66);
    @(negedge clk);
    check(10, "done one cycle", {31'b0, done_o}, 32'h0);

    // R10: latency of a zero-divisor request
    run_op(VECS[7], cyc);
    check(10, "dz latency", cyc, 32'd1);

    // R10: a start during a busy division is dropped
    va = VECS[2];
    vb = VECS[14];
    @(negedge clk);
    drive(va);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    check(10, "busy mid-run", {31'b0, busy_o}, 32'h1);
    drive(vb);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check(10, "ignored start dz", {31'b0, dz_o}, 32'h0);
    check(10, "ignored start q_data", q_data_o, 32'h0002000E);
    repeat (4) begin
      @(negedge clk);
      check(10, "no second done", {31'b0, done_o}, 32'h0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule